// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the byte-wide register interface of a 16550-compatible serial port. A host issues single-cycle read or write strobes with a 3-bit offset and an 8-bit data byte. The block holds the divisor bytes, line control, interrupt enable, modem control, FIFO control and scratch registers. It also presents the line status register, and reading it has side effects.

A small receive FIFO sits behind offset 0. Its capacity is the parameter `DEPTH` while the FIFO enable bit is set, and one byte while it is clear. Received bytes arrive on a strobe from the deserializer. In loopback mode, bytes the host writes to offset 0 go into the receive FIFO instead. Otherwise they leave as a one-cycle strobe on the byte output, and the transmitter always reports ready. The bit-level serializer and interrupt identification belong to neighbouring logic.

Top module: `uart_regbank`

## Requirements
- R1: After reset the divisor reads back as low byte 0x01 and high byte 0x00. Line control, interrupt enable, modem control, FIFO control and scratch are 0x00, the FIFO is empty, and the line status reads 0x60.
- R2: While line control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes, and the data path and interrupt enable register are untouched.
- R3: A data write (offset 0, line control bit 7 clear) raises `tx_valid` with `tx_data` for exactly one cycle when modem control bit 4 (loopback) is 0. When loopback is 1, it pushes the byte into the receive FIFO and `tx_valid` stays low.
- R4: `rx_strobe` pushes `rx_byte` into the FIFO when loopback is 0. It is ignored when loopback is 1.
- R5: A data read pops and returns the oldest FIFO byte in arrival order. Reading an empty FIFO returns 0x00 and leaves it empty.
- R6: The FIFO holds `DEPTH` bytes when FIFO control bit 0 is 1, and one byte when it is 0. A push into a full FIFO drops the byte and sets the overrun flag (line status bit 1).
- R7: A FIFO control write whose bit 0 differs from the stored bit 0 empties the FIFO.
- R8: A FIFO control write with bit 0 = 0 stores 0x00. With bit 0 = 1 it stores the written byte masked by 0xC9 (bits 0, 3, 7:6), and bit 1 = 1 empties the FIFO. Offset 2 reads the stored value.
- R9: A line status read (offset 5) returns bits 6 and 5 as 1, bit 7 as 0, bit 1 as overrun and bit 0 as FIFO non-empty. The read clears overrun.
- R10: Writes to offsets 5 and 6 change nothing. Offset 7 stores any byte. Interrupt enable keeps bits 3:0 and modem control keeps bits 4:0, and the upper bits of both read as 0.
- R11: A read of offset 6 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| rx_strobe | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |

## Verification
The assertions assume that the host never raises `rd_en` and `wr_en` in the same cycle. The assertions on the empty-read result and on overrun clearing also assume that no received byte arrives in the cycle of that read. The bench drives one access at a time on the falling edge, and it holds `rx_strobe` low whenever a read strobe is active, so both assumptions hold throughout. Results are sampled on the falling edge after the registering clock edge.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int DEPTH     = 16,
  parameter int DIV_RESET = 1843200 / 115200 / 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx_strobe,
  input  logic [7:0] rx_byte,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [7:0]    dll, dlh, lcr, scr, fcr;
  logic [3:0]    ier;
  logic [4:0]    mcr;
  logic          oe;
  logic [7:0]    rd_mux;

  wire dlab     = lcr[7];
  wire loop     = mcr[4];
  wire wr_data  = wr_en && addr == 3'd0 && !dlab;
  wire rd_data  = rd_en && addr == 3'd0 && !dlab;
  wire rd_lsr   = rd_en && addr == 3'd5;
  wire wr_fcr   = wr_en && addr == 3'd2;
  wire push_req = (wr_data && loop) || (rx_strobe && !loop);
  wire [7:0] push_byte = (wr_data && loop) ? wdata : rx_byte;
  wire [CW-1:0] cap = fcr[0] ? CW'(DEPTH) : CW'(1);
  wire nempty   = cnt != '0;
  wire pop      = rd_data && nempty;
  wire push     = push_req && (cnt < cap || pop);
  wire overrun  = push_req && !push;
  wire flush    = wr_fcr && ((wdata[0] != fcr[0]) || (wdata[0] && wdata[1]));

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push && !flush) mem[wp] <= push_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll <= 8'(DIV_RESET);
      dlh <= 8'(DIV_RESET >> 8);
      lcr <= '0;
      scr <= '0;
      fcr <= '0;
      ier <= '0;
      mcr <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: if (dlab) dll <= wdata;
        3'd1: if (dlab) dlh <= wdata; else ier <= wdata[3:0];
        3'd2: fcr <= wdata[0] ? (wdata & 8'hC9) : 8'h00;
        3'd3: lcr <= wdata;
        3'd4: mcr <= wdata[4:0];
        3'd7: scr <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      3'd0: rd_mux = dlab ? dll : (nempty ? mem[rp] : 8'h00);
      3'd1: rd_mux = dlab ? dlh : {4'b0, ier};
      3'd2: rd_mux = fcr;
      3'd3: rd_mux = lcr;
      3'd4: rd_mux = {3'b0, mcr};
      3'd5: rd_mux = {1'b0, 2'b11, 3'b000, oe, nempty};
      3'd6: rd_mux = 8'hFF;
      default: rd_mux = scr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      oe <= 1'b0;
      tx_valid <= 1'b0;
      tx_data <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      if (overrun) oe <= 1'b1;
      else if (rd_lsr) oe <= 1'b0;
      tx_valid <= wr_data && !loop;
      if (wr_data && !loop) tx_data <= wdata;
    end
  end

  p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n) cnt <= cap);
  p_lsr_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lsr |=> rdata[7:5] == 3'b011);
  p_oe_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lsr && !rx_strobe && !wr_en |=> !oe);
  p_undef_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 3'd6 |=> rdata == 8'hFF);
  p_toggle_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fcr && (wdata[0] != fcr[0]) |=> cnt == '0 && wp == rp);
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !nempty && !rx_strobe |=> rdata == 8'h00 && cnt == '0);
  p_loop_no_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && loop |=> !tx_valid);
endmodule

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, rx_strobe = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rx_byte = '0, rdata, tx_data;
  logic tx_valid;
  int checks = 0, fails = 0, cyc = 0;

  uart_regbank u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
                   .rx_strobe, .rx_byte, .tx_valid, .tx_data);

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<=20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic do_rx(logic [7:0] b);
    @(negedge clk); rx_strobe = 1; rx_byte = b;
    @(negedge clk); rx_strobe = 0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] v;
    do_rd(a, v);
    check(req, v, exp);
  endtask

  // {req[3:0], op (1 = read), addr[2:0], data[7:0], expected[7:0]}
  localparam logic [23:0] TBL [24] = '{
    {4'd10, 1'b0, 3'd7, 8'hA5, 8'h00}, {4'd10, 1'b1, 3'd7, 8'h00, 8'hA5}, // R10 scratch
    {4'd2,  1'b0, 3'd3, 8'h83, 8'h00}, {4'd2,  1'b0, 3'd0, 8'h0C, 8'h00}, // R2 divisor
    {4'd2,  1'b0, 3'd1, 8'h5A, 8'h00}, {4'd2,  1'b1, 3'd0, 8'h00, 8'h0C},
    {4'd2,  1'b1, 3'd1, 8'h00, 8'h5A}, {4'd2,  1'b1, 3'd3, 8'h00, 8'h83},
    {4'd2,  1'b0, 3'd3, 8'h03, 8'h00}, {4'd2,  1'b1, 3'd1, 8'h00, 8'h00},
    {4'd2,  1'b1, 3'd3, 8'h00, 8'h03},
    {4'd10, 1'b0, 3'd1, 8'hFF, 8'h00}, {4'd10, 1'b1, 3'd1, 8'h00, 8'h0F}, // R10 masks
    {4'd10, 1'b0, 3'd4, 8'hEF, 8'h00}, {4'd10, 1'b1, 3'd4, 8'h00, 8'h0F},
    {4'd10, 1'b0, 3'd5, 8'h12, 8'h00}, {4'd10, 1'b1, 3'd5, 8'h00, 8'h60},
    {4'd10, 1'b0, 3'd6, 8'h34, 8'h00}, {4'd11, 1'b1, 3'd6, 8'h00, 8'hFF}, // R11
    {4'd8,  1'b1, 3'd2, 8'h00, 8'h00}, {4'd8,  1'b0, 3'd2, 8'hFF, 8'h00}, // R8
    {4'd8,  1'b1, 3'd2, 8'h00, 8'hC9}, {4'd8,  1'b0, 3'd2, 8'h06, 8'h00},
    {4'd8,  1'b1, 3'd2, 8'h00, 8'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk("R1 lsr", 3'd5, 8'h60);
    rd_chk("R1 fcr", 3'd2, 8'h00);
    rd_chk("R1 scratch", 3'd7, 8'h00);
    rd_chk("R1 ier", 3'd1, 8'h00);
    do_wr(3'd3, 8'h80);
    rd_chk("R1 div low", 3'd0, 8'h01);
    rd_chk("R1 div high", 3'd1, 8'h00);
    do_wr(3'd3, 8'h00);

    for (int i = 0; i < 24; i++) begin
      if (TBL[i][19]) begin
        logic [7:0] v;
        do_rd(TBL[i][18:16], v);
        check($sformatf("R%0d table[%0d]", TBL[i][23:20], i), v, TBL[i][7:0]);
      end else
        do_wr(TBL[i][18:16], TBL[i][15:8]);
    end

    // R3 transmit path, one-cycle strobe, nothing enters the FIFO
    do_wr(3'd0, 8'h3C);
    check("R3 tx_valid", {7'b0, tx_valid}, 8'h01);
    check("R3 tx_data", tx_data, 8'h3C);
    @(negedge clk);
    check("R3 tx_valid drop", {7'b0, tx_valid}, 8'h00);
    rd_chk("R3 fifo empty", 3'd5, 8'h60);

    // R6 depth one, overrun; R9 clear on read; R5 pop and empty read
    do_rx(8'h11);
    do_rx(8'h22);
    rd_chk("R6 overrun depth1", 3'd5, 8'h63);
    rd_chk("R9 overrun cleared", 3'd5, 8'h61);
    rd_chk("R5 pop", 3'd0, 8'h11);
    rd_chk("R5 empty read", 3'd0, 8'h00);
    rd_chk("R5 stays empty", 3'd5, 8'h60);

    // R6 full depth in loopback; R3 no tx in loopback
    do_wr(3'd2, 8'h01);
    do_wr(3'd4, 8'h10);
    for (int i = 0; i < 20; i++) begin
      do_wr(3'd0, 8'h40 + 8'(i));
      if (i == 0) check("R3 loopback no tx", {7'b0, tx_valid}, 8'h00);
    end
    rd_chk("R6 overrun full", 3'd5, 8'h63);
    for (int i = 0; i < 16; i++)
      rd_chk($sformatf("R5 order %0d", i), 3'd0, 8'h40 + 8'(i));
    rd_chk("R5 drained", 3'd5, 8'h60);

    // R4 receive strobe ignored in loopback
    do_rx(8'h77);
    rd_chk("R4 rx ignored", 3'd5, 8'h60);

    // R7 enable toggles flush
    do_wr(3'd0, 8'h01);
    do_wr(3'd0, 8'h02);
    do_wr(3'd0, 8'h03);
    do_wr(3'd2, 8'h00);
    rd_chk("R7 disable flush", 3'd5, 8'h60);
    do_wr(3'd0, 8'hAA);
    do_wr(3'd2, 8'h01);
    rd_chk("R7 enable flush", 3'd5, 8'h60);

    // R8 receive-reset bit
    do_wr(3'd0, 8'hB1);
    do_wr(3'd0, 8'hB2);
    do_wr(3'd2, 8'h03);
    rd_chk("R8 rx reset", 3'd5, 8'h60);
    rd_chk("R8 fcr kept", 3'd2, 8'h01);
    rd_chk("R8 nothing left", 3'd0, 8'h00);

    // R4 receive path outside loopback
    do_wr(3'd4, 8'h00);
    do_rx(8'h5E);
    rd_chk("R4 rx pushed", 3'd0, 8'h5E);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule